// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Deep FIFOs

This block is an asynchronous serial transmitter and receiver that a processor reaches through two 32-bit words. Each frame has a low start bit, eight data bits sent least significant first, an odd parity bit and one high stop bit. The bit rate comes from a fixed divider of the system clock with 16x oversampling. The defaults give 115200 baud from a 50 MHz clock. Characters written by software queue in a transmit FIFO. Characters taken from the line queue in a receive FIFO, and each one carries its own parity-error flag.

Word 0 (`bus_sel` = 0) is the data word. A read returns the head character, its parity flag and the receive fill count. Word 1 (`bus_sel` = 1) is the control word. It returns the transmit free space, two interrupt enables and two pending flags. The pending flags rise when a FIFO level passes a threshold, so the processor can move a batch of characters for each interrupt instead of taking one interrupt per character. Reads are combinational while `bus_rd` is high. A pop or push takes effect on the clock edge that ends the access. FIFO_DEPTH must be a power of two.

Top module: `serial_port_mm`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, the data word reads 0x00000000, and the control word reads FIFO_DEPTH in bits 31:16 with all other bits 0. While the receive FIFO is empty, bits 15:0 of the data word read 0.
- R2: Each transmitted frame is: start bit 0, data bits LSB first, parity bit equal to the XNOR-reduction of the data (odd parity), then stop bit 1. Each bit lasts 16 ticks of CLK_HZ/(16*BAUD) clocks. Characters leave in the order they were written.
- R3: A received character appears in data-word bits 7:0, and the receive count appears zero-extended in bits 31:16. A data-word read with `bus_be[0]` or `bus_be[1]` set removes the head character on that edge.
- R4: Data-word bit 9 is 1 exactly when the character shown in bits 7:0 arrived with a data-plus-parity ones count that was even. This flag stays paired with its own character through the FIFO.
- R5: A data-word read with `bus_be[1:0]` = 00 (upper half only) leaves the receive count and the head character unchanged.
- R6: A data-word write with `bus_be[0]` set queues `bus_wdata[7:0]` for transmission and leaves the receive count unchanged.
- R7: A character that completes while the receive FIFO holds FIFO_DEPTH entries is discarded. The stored characters are kept in order.
- R8: A write while the transmit FIFO is full is discarded. Starting from an idle port, FIFO_DEPTH+1 back-to-back characters are accepted, because one moves straight into the shifter. The control word then reports 0 free space.
- R9: Control bit 8 (receive pending) is 1 exactly when receive enable is set and the receive count is greater than IRQ_LEVEL.
- R10: Control bit 9 (transmit pending) is 1 exactly when transmit enable is set and the transmit free space is greater than IRQ_LEVEL. `irq` is the OR of the two pending bits.
- R11: A low pulse on `rxd` that has ended before the middle of the start bit is rejected, and no character is stored.
- R12: A frame whose stop bit samples low is discarded.
- R13: A control-word write with `bus_be[0]` set loads receive enable from bit 0 and transmit enable from bit 1. Both read back in those bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Word select: 0 data word, 1 control word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a clock of 32 times the baud rate, so the divider is 2 and one bit lasts 32 clocks. It uses FIFO_DEPTH = 8 and IRQ_LEVEL = 3. With these values the overflow of both FIFOs, the exact threshold crossing of both pending flags, and a full-transmit-FIFO burst each take a handful of frames. A false start pulse of four oversample ticks and a frame with a low stop bit exercise the receiver's rejection paths.

// File: rtl/serial_port_mm.sv
module serial_port_mm #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 115_200,
  parameter int FIFO_DEPTH = 256,
  parameter int IRQ_LEVEL  = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  localparam int DIV   = (CLK_HZ / (BAUD * 16)) > 0 ? CLK_HZ / (BAUD * 16) : 1;
  localparam int DIV_W = DIV > 1 ? $clog2(DIV) : 1;
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int CW    = AW + 1;

  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  assign tick = (div_cnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || tick) div_cnt <= '0;
    else                div_cnt <= div_cnt + 1'b1;
  end

  logic wr_data_b0, rd_data_lo, wr_ctrl_b0;
  assign wr_data_b0 = bus_wr & ~bus_sel & bus_be[0];
  assign wr_ctrl_b0 = bus_wr &  bus_sel & bus_be[0];
  assign rd_data_lo = bus_rd & ~bus_sel & (bus_be[0] | bus_be[1]);

  logic re, we;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re <= 1'b0;
      we <= 1'b0;
    end else if (wr_ctrl_b0) begin
      re <= bus_wdata[0];
      we <= bus_wdata[1];
    end
  end

  // transmit FIFO
  logic [7:0]    tx_mem [FIFO_DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt, tx_free;
  logic          tx_push, tx_pop, tx_busy;

  assign tx_free = CW'(FIFO_DEPTH) - tx_cnt;
  assign tx_push = wr_data_b0 & (tx_free != '0);
  assign tx_pop  = tick & ~tx_busy & (tx_cnt != '0);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      case ({tx_push, tx_pop})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  // transmit shifter
  logic [10:0] tx_sh;
  logic [3:0]  tx_ovs, tx_bitn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_ovs  <= '0;
      tx_bitn <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, ~^tx_mem[tx_rp], tx_mem[tx_rp], 1'b0};
      tx_ovs  <= '0;
      tx_bitn <= '0;
    end else if (tick && tx_busy) begin
      tx_ovs <= tx_ovs + 1'b1;
      if (tx_ovs == 4'd15) begin
        tx_sh   <= {1'b1, tx_sh[10:1]};
        tx_bitn <= tx_bitn + 1'b1;
        if (tx_bitn == 4'd10) tx_busy <= 1'b0;
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receiver
  logic       rx_s1, rx_s2, rx_busy;
  logic [3:0] rx_ovs, rx_bitn;
  logic [8:0] rx_sh;
  logic       rx_mid, rx_done;

  assign rx_mid  = tick & rx_busy & (rx_ovs == 4'd7);
  assign rx_done = rx_mid & (rx_bitn == 4'd10) & rx_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_busy <= 1'b0;
      rx_ovs  <= '0;
      rx_bitn <= '0;
      rx_sh   <= '0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (tick) begin
        if (!rx_busy) begin
          if (!rx_s2) begin
            rx_busy <= 1'b1;
            rx_ovs  <= '0;
            rx_bitn <= '0;
          end
        end else begin
          rx_ovs <= rx_ovs + 1'b1;
          if (rx_ovs == 4'd7) begin
            if (rx_bitn == 4'd0) begin
              if (rx_s2) rx_busy <= 1'b0;
              else       rx_bitn <= 4'd1;
            end else if (rx_bitn < 4'd10) begin
              rx_sh   <= {rx_s2, rx_sh[8:1]};
              rx_bitn <= rx_bitn + 1'b1;
            end else begin
              rx_busy <= 1'b0;
            end
          end
        end
      end
    end
  end

  // receive FIFO: {parity error, character}
  logic [8:0]    rx_mem [FIFO_DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_wr, rx_pop;
  logic [8:0]    rx_head;

  assign rx_wr   = rx_done & (rx_cnt != CW'(FIFO_DEPTH));
  assign rx_pop  = rd_data_lo & (rx_cnt != '0);
  assign rx_head = (rx_cnt != '0) ? rx_mem[rx_rp] : 9'd0;

  always_ff @(posedge clk) begin
    if (rx_wr) rx_mem[rx_wp] <= {~^rx_sh, rx_sh[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_wr)  rx_wp <= rx_wp + 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      case ({rx_wr, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  logic ri, wi;
  assign ri  = re & (rx_cnt  > CW'(IRQ_LEVEL));
  assign wi  = we & (tx_free > CW'(IRQ_LEVEL));
  assign irq = ri | wi;

  assign bus_rdata = bus_sel
    ? {16'(tx_free), 6'd0, wi, ri, 6'd0, we, re}
    : {16'(rx_cnt),  6'd0, rx_head[8], 1'b0, rx_head[7:0]};

endmodule

// File: rtl/serial_port_mm_chk.sv
module serial_port_mm_chk #(
  parameter int CW = 9,
  parameter int FIFO_DEPTH = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_rd,
  input logic [3:0]    bus_be,
  input logic          rx_wr,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_free,
  input logic          re,
  input logic          we,
  input logic          irq,
  input logic          txd
);
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(FIFO_DEPTH)); // R7
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_free <= CW'(FIFO_DEPTH)); // R8
  AST_HALF_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_sel && bus_be[1:0] == 2'b00 && !rx_wr) |=> rx_cnt == $past(rx_cnt)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (re || we)); // R10
  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(txd) |=> !txd); // R2
endmodule

bind serial_port_mm serial_port_mm_chk #(.CW(CW), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_be(bus_be),
  .rx_wr(rx_wr), .rx_cnt(rx_cnt), .tx_free(tx_free), .re(re), .we(we),
  .irq(irq), .txd(txd)
);

// File: tb/serial_port_mm_bench.sv
module serial_port_mm_bench;
  localparam int BAUD  = 115_200;
  localparam int CLKHZ = BAUD * 32;
  localparam int DEPTH = 8;
  localparam int LEVEL = 3;
  localparam int BIT   = 32;
  localparam logic [8:0] VEC [0:5] = '{9'h055, 9'h1A3, 9'h000, 9'h1FF, 9'h081, 9'h17E};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_be = 4'h0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rxd = 1'b1, txd, irq;

  int n_tests = 0, n_fail = 0, tx_n = 0;
  logic [7:0] tx_ch [0:63];
  logic       tx_par [0:63];
  logic       tx_stp [0:63];
  bit done = 0;

  always #4 clk = ~clk;

  serial_port_mm #(.CLK_HZ(CLKHZ), .BAUD(BAUD), .FIFO_DEPTH(DEPTH), .IRQ_LEVEL(LEVEL)) u_serial_port_mm (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic bus_read(input logic sel, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_be = be; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'h0;
  endtask

  task automatic send_rx(input logic [7:0] ch, input logic bad_par, input logic bad_stop);
    logic [10:0] fr;
    fr = {~bad_stop, (~^ch) ^ bad_par, ch, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = fr[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    for (int i = 0; i < 20000 && tx_n < n; i++) @(negedge clk);
  endtask

  // transmit line monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        logic [9:0] b;
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = txd;
        end
        if (tx_n < 64) begin
          tx_ch[tx_n] = b[7:0]; tx_par[tx_n] = b[8]; tx_stp[tx_n] = b[9];
        end
        tx_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_read(1'b0, 4'b1100, d); chk("R1 data word", d, 32'h0);
    bus_read(1'b1, 4'b1111, d); chk("R1 ctrl word", d, 32'(DEPTH) << 16);

    // vector table: {bad parity, character}
    foreach (VEC[k]) begin
      base = tx_n;
      bus_write(1'b0, 4'b0001, {24'd0, VEC[k][7:0]});
      wait_tx(base + 1);
      chk("R2 tx data", {24'd0, tx_ch[base]}, {24'd0, VEC[k][7:0]});
      chk("R2 tx odd parity", {31'd0, tx_par[base]}, {31'd0, ~^VEC[k][7:0]});
      chk("R2 tx stop", {31'd0, tx_stp[base]}, 32'd1);
      send_rx(VEC[k][7:0], VEC[k][8], 1'b0);
      bus_read(1'b0, 4'b1100, d); chk("R5 upper read count", d[31:16], 32'd1);
      bus_read(1'b0, 4'b1100, d); chk("R5 still present", d[31:16], 32'd1);
      bus_read(1'b0, 4'b1111, d);
      chk("R3 rx char", {24'd0, d[7:0]}, {24'd0, VEC[k][7:0]});
      chk("R4 parity flag", {31'd0, d[9]}, {31'd0, VEC[k][8]});
      bus_read(1'b0, 4'b1100, d); chk("R3 popped", d[31:16], 32'd0);
    end

    // R11 false start, R12 bad stop
    rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    bus_read(1'b0, 4'b1100, d); chk("R11 glitch ignored", d[31:16], 32'd0);
    send_rx(8'h5A, 1'b0, 1'b1);
    bus_read(1'b0, 4'b1100, d); chk("R12 bad stop dropped", d[31:16], 32'd0);

    // R9 receive threshold, R7 overflow, R6 write isolation
    bus_write(1'b1, 4'b0001, 32'h1);
    for (int i = 0; i < 3; i++) send_rx(8'hA0 + 8'(i), 1'b0, 1'b0);
    bus_read(1'b1, 4'b1111, d); chk("R9 ri at level", {31'd0, d[8]}, 32'd0);
    chk("R9 irq at level", {31'd0, irq}, 32'd0);
    send_rx(8'hA3, 1'b0, 1'b0);
    bus_read(1'b1, 4'b1111, d); chk("R9 ri above level", {31'd0, d[8]}, 32'd1);
    chk("R10 irq from ri", {31'd0, irq}, 32'd1);
    for (int i = 4; i < 10; i++) send_rx(8'hA0 + 8'(i), 1'b0, 1'b0);
    bus_read(1'b0, 4'b1100, d); chk("R7 count capped", d[31:16], 32'(DEPTH));
    base = tx_n;
    bus_write(1'b0, 4'b0001, 32'h3C);
    bus_read(1'b0, 4'b1100, d); chk("R6 rx count kept", d[31:16], 32'(DEPTH));
    wait_tx(base + 1);
    chk("R6 tx char", {24'd0, tx_ch[base]}, 32'h3C);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(1'b0, 4'b0011, d);
      chk("R7 order kept", {24'd0, d[7:0]}, 32'hA0 + 32'(i));
    end
    bus_read(1'b0, 4'b1100, d); chk("R7 extras lost", d[31:16], 32'd0);
    bus_read(1'b1, 4'b1111, d); chk("R9 ri cleared", {31'd0, d[8]}, 32'd0);

    // R13 enables, R10 transmit threshold
    bus_write(1'b1, 4'b0001, 32'h3);
    bus_read(1'b1, 4'b1111, d);
    chk("R13 enables readback", {30'd0, d[1:0]}, 32'd3);
    chk("R10 wi idle", {31'd0, d[9]}, 32'd1);
    chk("R10 irq from wi", {31'd0, irq}, 32'd1);
    base = tx_n;
    for (int i = 0; i < 6; i++) bus_write(1'b0, 4'b0001, 32'h60 + 32'(i));
    bus_read(1'b1, 4'b1111, d);
    chk("R10 free space", d[31:16], 32'd3);
    chk("R10 wi at level", {31'd0, d[9]}, 32'd0);
    chk("R10 irq low", {31'd0, irq}, 32'd0);
    wait_tx(base + 6);
    for (int i = 0; i < 6; i++) chk("R2 tx order", {24'd0, tx_ch[base + i]}, 32'h60 + 32'(i));

    // R8 transmit overflow
    bus_write(1'b1, 4'b0001, 32'h0);
    base = tx_n;
    for (int i = 0; i < 12; i++) bus_write(1'b0, 4'b0001, 32'h40 + 32'(i));
    bus_read(1'b1, 4'b1111, d); chk("R8 no free space", d[31:16], 32'd0);
    wait_tx(base + DEPTH + 1);
    repeat (30 * BIT) @(negedge clk);
    chk("R8 accepted count", 32'(tx_n - base), 32'(DEPTH + 1));
    for (int i = 0; i <= DEPTH; i++) chk("R8 kept chars", {24'd0, tx_ch[base + i]}, 32'h40 + 32'(i));

    summary();
  end
endmodule